// File: doc/BRIEF.md
# Flash Block Write-Lock Bank

This block guards a 512 KB flash array made of eight 64 KB blocks. It holds one lock bit for each block and decides, request by request, whether an array write or erase may go ahead. Every lock comes up locked after any reset. A single plain register write clears or sets a lock. No unlock command sequence is involved.

The host reaches the locks through single-cycle register requests at fixed addresses. Register n sits at `0xFFB8_0002 + n * 0x1_0000`. Two active-low protect pins are also part of the decision, and they act independently of the locks. `prot_top_n` covers the top block only. `prot_low_n` covers every other block. Either a set lock or a low protect pin on its own is enough to refuse a write.

The edges of the block carry no data stream. A register request and an array request are each taken in the cycle they are raised. There is no ready signal and no back-pressure, so a requester may raise a new request every cycle.

Top module: `slk_lockbank`

## Requirements
- R1: Lock register n is decoded at address `0xFFB8_0002 + n * 0x1_0000` for n = 0..7. A read request to it returns the lock value on `reg_rdata`, with `reg_rvalid` high, in the cycle after the request.
- R2: While `rst_n` is low, and after it rises, all eight locks hold 0x01 (locked) until they are written.
- R3: When `reinit_n` is low at a rising clock edge, all eight locks return to 0x01. This also overrides a register write made in the same cycle.
- R4: A single register write updates the lock from bit 0 of `reg_wdata`, taking effect at that clock edge. Writing 0x00 unlocks and writing 0x01 relocks. Bits 7..1 of the write data are ignored, and bits 7..1 of the read data are always zero.
- R5: A register request whose address matches no lock register leaves every lock unchanged. If it is a read, it returns 0x00.
- R6: `arr_allow` is high in the same cycle as `arr_req` only when the target block's lock is 0 and that block's protect pin is high. The target block is `arr_addr[18:16]`.
- R7: `prot_top_n` low refuses writes to block 7 and to no other block. `prot_low_n` low refuses writes to blocks 0..6 and not to block 7. Both pins refuse regardless of the lock state.
- R8: A refused array request (`arr_req` high, `arr_allow` low) raises `arr_reject` for exactly the following cycle. `arr_reject` is low in every other cycle.
- R9: A read request never changes any lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; all locks set |
| reinit_n | input | 1 | Synchronous active-low re-initialise; all locks set |
| prot_low_n | input | 1 | Active-low protect for blocks 0..6 |
| prot_top_n | input | 1 | Active-low protect for block 7 |
| reg_req | input | 1 | Register request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 32 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| arr_req | input | 1 | Array write/erase request |
| arr_addr | input | 19 | Byte address inside the array |
| arr_allow | output | 1 | Request permitted, same cycle |
| arr_reject | output | 1 | Refusal pulse, cycle after a refused request |

## Verification
`arr_allow` is combinational, so the bench samples it 1 ns after driving a request on the falling edge, before the next rising edge. `arr_reject` and the read data pass through one register each. They are sampled on the falling edge after the rising edge that captured the request. A lock write takes effect at the rising edge that sees it, so the read-back issued at the next falling edge already sees the new value. The bench sweeps all 256 lock patterns against every block and all four protect-pin combinations. At each step it compares against a lock model kept in the bench.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int unsigned SLK_BLOCKS    = 8;
  localparam int unsigned SLK_STRIDE_LG = 16;
  localparam int unsigned SLK_AW        = 32;
  localparam int unsigned SLK_DW        = 8;
  localparam logic [31:0] SLK_BASE      = 32'hFFB8_0002;

  typedef enum logic { ACC_READ = 1'b0, ACC_WRITE = 1'b1 } acc_kind_e;
endpackage

// File: rtl/slk_decode.sv
module slk_decode #(
  parameter int unsigned       AW        = 32,
  parameter int unsigned       STRIDE_LG = 16,
  parameter int unsigned       N_BLK     = 8,
  parameter int unsigned       IDX_W     = 3,
  parameter logic [AW-1:0]     BASE      = '0
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned HI_W = AW - STRIDE_LG;

  logic [AW-1:0] off;

  assign off = addr - BASE;
  // aligned to a stride boundary and within the block count
  assign hit = (off[STRIDE_LG-1:0] == '0) && (off[AW-1:STRIDE_LG] < HI_W'(N_BLK));
  assign idx = off[STRIDE_LG +: IDX_W];
endmodule

// File: rtl/slk_bank.sv
module slk_bank #(
  parameter int unsigned N_BLK = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reinit_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic [N_BLK-1:0] locks
);
  genvar g;
  generate
    for (g = 0; g < N_BLK; g++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 locks[g] <= 1'b1;
        else if (!reinit_n)                         locks[g] <= 1'b1;
        else if (wr_en && (wr_idx == IDX_W'(g)))    locks[g] <= wr_bit;
      end
    end
  endgenerate
endmodule

// File: rtl/slk_gate.sv
module slk_gate #(
  parameter int unsigned N_BLK = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N_BLK-1:0] locks,
  input  logic             prot_low_n,
  input  logic             prot_top_n,
  input  logic             req,
  input  logic [IDX_W-1:0] blk,
  output logic             allow
);
  logic pin_ok;

  always_comb begin
    pin_ok = (blk == IDX_W'(N_BLK - 1)) ? prot_top_n : prot_low_n;
    allow  = req && !locks[blk] && pin_ok;
  end
endmodule

// File: rtl/slk_lockbank.sv
module slk_lockbank
  import slk_pkg::*;
#(
  parameter int unsigned       N_BLK     = SLK_BLOCKS,
  parameter int unsigned       STRIDE_LG = SLK_STRIDE_LG,
  parameter int unsigned       AW        = SLK_AW,
  parameter int unsigned       DW        = SLK_DW,
  parameter logic [SLK_AW-1:0] BASE      = SLK_BASE,
  localparam int unsigned      IDX_W     = $clog2(N_BLK),
  localparam int unsigned      ARR_AW    = STRIDE_LG + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit_n,
  input  logic              prot_low_n,
  input  logic              prot_top_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic              arr_req,
  input  logic [ARR_AW-1:0] arr_addr,
  output logic              arr_allow,
  output logic              arr_reject
);
  logic             reg_hit;
  logic [IDX_W-1:0] reg_idx;
  logic [N_BLK-1:0] lock_q;
  logic [IDX_W-1:0] arr_blk;
  logic             wr_en;
  acc_kind_e        kind;
  logic             unused_bits;

  assign kind        = acc_kind_e'(reg_we);
  assign wr_en       = reg_req && (kind == ACC_WRITE) && reg_hit;
  assign arr_blk     = arr_addr[ARR_AW-1 -: IDX_W];
  assign unused_bits = ^{reg_wdata[DW-1:1], arr_addr[STRIDE_LG-1:0]};

  slk_decode #(
    .AW(AW), .STRIDE_LG(STRIDE_LG), .N_BLK(N_BLK), .IDX_W(IDX_W),
    .BASE(AW'(BASE))
  ) u_decode (
    .addr(reg_addr), .hit(reg_hit), .idx(reg_idx)
  );

  slk_bank #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .reinit_n(reinit_n),
    .wr_en(wr_en), .wr_idx(reg_idx), .wr_bit(reg_wdata[0]),
    .locks(lock_q)
  );

  slk_gate #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_gate (
    .locks(lock_q), .prot_low_n(prot_low_n), .prot_top_n(prot_top_n),
    .req(arr_req), .blk(arr_blk), .allow(arr_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      arr_reject <= 1'b0;
    end else begin
      reg_rvalid <= reg_req && (kind == ACC_READ);
      if (reg_req && (kind == ACC_READ))
        reg_rdata <= reg_hit ? DW'(lock_q[reg_idx]) : '0;
      arr_reject <= arr_req && !arr_allow;
    end
  end
endmodule

// File: rtl/slk_lockbank_chk.sv
module slk_lockbank_chk #(
  parameter int unsigned N_BLK = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reinit_n,
  input logic             prot_low_n,
  input logic             prot_top_n,
  input logic             reg_req,
  input logic             reg_we,
  input logic             reg_hit,
  input logic [DW-1:0]    reg_rdata,
  input logic             reg_rvalid,
  input logic [N_BLK-1:0] locks,
  input logic             arr_req,
  input logic [IDX_W-1:0] arr_blk,
  input logic             arr_allow,
  input logic             arr_reject
);
  p_reinit_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reinit_n |=> (&locks));

  p_top_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !prot_top_n && arr_blk == IDX_W'(N_BLK - 1)) |-> !arr_allow);

  p_low_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !prot_low_n && arr_blk != IDX_W'(N_BLK - 1)) |-> !arr_allow);

  p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && locks[arr_blk]) |-> !arr_allow);

  p_reject_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_allow) |=> arr_reject);

  p_no_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_req && !arr_allow) |=> !arr_reject);

  p_miss_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_hit && reinit_n) |=> $stable(locks));

  p_miss_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && !reg_hit) |=> (reg_rdata == '0));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> (reg_rdata[DW-1:1] == '0));

  p_read_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && reinit_n) |=> $stable(locks));
endmodule

bind slk_lockbank slk_lockbank_chk #(.N_BLK(N_BLK), .IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reinit_n(reinit_n),
  .prot_low_n(prot_low_n), .prot_top_n(prot_top_n),
  .reg_req(reg_req), .reg_we(reg_we), .reg_hit(reg_hit),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .locks(lock_q),
  .arr_req(arr_req), .arr_blk(arr_blk),
  .arr_allow(arr_allow), .arr_reject(arr_reject)
);

// File: tb/slk_lockbank_tb.sv
`timescale 1ns/1ps
module slk_lockbank_tb;
  localparam logic [31:0] BASE   = 32'hFFB8_0002;
  localparam logic [31:0] STRIDE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reinit_n = 1'b1;
  logic        prot_low_n = 1'b1;
  logic        prot_top_n = 1'b1;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;
  logic        arr_req = 1'b0;
  logic [18:0] arr_addr = '0;
  logic        arr_allow;
  logic        arr_reject;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'hFF;

  always #4 clk = ~clk;

  slk_lockbank u_dut (
    .clk(clk), .rst_n(rst_n), .reinit_n(reinit_n),
    .prot_low_n(prot_low_n), .prot_top_n(prot_top_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .arr_req(arr_req), .arr_addr(arr_addr),
    .arr_allow(arr_allow), .arr_reject(arr_reject)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [31:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    chk(reg_rvalid === 1'b1, req, int'(reg_rvalid), 1);
    chk(reg_rdata === exp, req, int'(reg_rdata), int'(exp));
  endtask

  task automatic read_all(input string req);
    for (int n = 0; n < 8; n++)
      reg_read(BASE + STRIDE * n, {7'd0, model[n]}, req);
  endtask

  task automatic arr_try(input int blk, input bit lo, input bit top, input string req);
    bit exp;
    @(negedge clk);
    arr_req = 1'b1; prot_low_n = lo; prot_top_n = top;
    arr_addr = {blk[2:0], 16'h3C5A ^ 16'(blk)};
    exp = !model[blk] && ((blk == 7) ? top : lo);
    #1;
    chk(arr_allow === exp, req, int'(arr_allow), int'(exp));
    @(negedge clk);
    arr_req = 1'b0;
    chk(arr_reject === !exp, "R8", int'(arr_reject), int'(!exp));
    prot_low_n = 1'b1; prot_top_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk(reg_rvalid === 1'b0, "R2", int'(reg_rvalid), 0);
    chk(arr_reject === 1'b0, "R8", int'(arr_reject), 0);
    rst_n = 1'b1;
    model = 8'hFF;
    read_all("R2");
    for (int b = 0; b < 8; b++) arr_try(b, 1'b1, 1'b1, "R2");

    // sweep every lock pattern against every block and pin combination
    for (int pat = 0; pat < 256; pat++) begin
      for (int n = 0; n < 8; n++) begin
        reg_write(BASE + STRIDE * n, {7'(pat + n * 5), pat[n]}); // R4 upper bits ignored
        model[n] = pat[n];
      end
      read_all("R1");
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 4; p++)
          arr_try(b, p[0], p[1], (p == 3) ? "R6" : "R7");
      if (pat % 51 == 0) begin
        reg_write(BASE + 1, 8'h00);               // R5 off stride
        reg_write(BASE - STRIDE, 8'h00);          // R5 below range
        reg_write(BASE + STRIDE * 8, 8'h00);      // R5 above range
        reg_write(BASE + STRIDE * 3 + 32'h8000, {7'd0, ~pat[3]});
        read_all("R5");
        read_all("R9");
      end
    end

    // write 0x00 then 0x01 on one block
    reg_write(BASE + STRIDE * 4, 8'h00); model[4] = 1'b0;
    reg_read(BASE + STRIDE * 4, 8'h00, "R4");
    reg_write(BASE + STRIDE * 4, 8'h01); model[4] = 1'b1;
    reg_read(BASE + STRIDE * 4, 8'h01, "R4");

    // miss reads return zero
    reg_read(BASE + 2, 8'h00, "R5");
    reg_read(BASE - STRIDE, 8'h00, "R5");
    reg_read(BASE + STRIDE * 8, 8'h00, "R5");
    reg_read(32'h0000_0002, 8'h00, "R5");

    // re-initialise overrides a same-cycle write
    for (int n = 0; n < 8; n++) reg_write(BASE + STRIDE * n, 8'h00);
    model = 8'h00;
    read_all("R4");
    @(negedge clk);
    reinit_n = 1'b0; reg_req = 1'b1; reg_we = 1'b1;
    reg_addr = BASE + STRIDE * 3; reg_wdata = 8'h00;
    @(negedge clk);
    reinit_n = 1'b1; reg_req = 1'b0; reg_we = 1'b0;
    model = 8'hFF;
    read_all("R3");
    for (int b = 0; b < 8; b++) arr_try(b, 1'b1, 1'b1, "R3");

    // asynchronous reset in mid-operation
    for (int n = 0; n < 8; n++) reg_write(BASE + STRIDE * n, 8'h00);
    model = 8'h00;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model = 8'hFF;
    read_all("R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule